// File: doc/BRIEF.md
# UART Receiver with Activity Flag

This block is the receive half of a small register-mapped UART. It watches a serial input line at sixteen samples per bit, using a one-cycle oversampling tick supplied from outside. A falling line is taken as a possible start bit. The start bit is accepted only if a sample taken half a bit later is still low. The block then collects eight or nine data bits, least significant first, and checks the stop bit.

A completed frame lands in a byte-wide data register. In nine-bit mode the extra bit goes into a separate one-bit register, which logically sits just above the byte's MSB. The block raises a data-full flag, and a read strobe for the data register clears it. Once that read has happened, the next frame may overwrite both the byte and the ninth bit. A frame that completes while data-full is still set is discarded and raises an overrun flag.

A receiver-active flag is set as soon as a start bit begins and stays set until the line has been idle for one whole character time. An idle indication reports that same condition. Software can use the pair to tell whether a character is in flight.

Top module: `uart_rx_active`

## Requirements
- R1: After reset, data_full, frame_err, overrun, rx_active, line_idle, rx_bit9 and rx_data are all 0.
- R2: A low line sampled on an os_tick while the receiver is waiting sets rx_active on that clock edge. If the sample 8 ticks later is high, the start is abandoned: rx_active clears and no data is delivered.
- R3: In 8-bit mode (nine_bit=0) a frame is 1 low start bit, 8 data bits LSB first, and 1 stop bit, each 16 ticks long. The byte appears on rx_data, rx_bit9 reads 0, and data_full goes to 1.
- R4: In 9-bit mode (nine_bit=1) the ninth data bit received goes to rx_bit9, and the first eight go to rx_data.
- R5: frame_err is loaded with the inverse of the stop-bit sample for every accepted frame (stop sample 0 gives frame_err=1).
- R6: A data_rd pulse clears data_full and overrun on the next edge when no frame completes in that cycle. rx_data, rx_bit9 and frame_err keep their values.
- R7: A frame that completes while data_full=1 and data_rd=0 is dropped. rx_data, rx_bit9 and frame_err are unchanged and overrun goes to 1.
- R8: A frame that completes in the same cycle as a data_rd pulse is accepted. data_full stays 1, overrun is 0, and rx_data holds the new byte.
- R9: After 160 consecutive high tick samples (176 in 9-bit mode), line_idle is 1 and rx_active is 0. Any low tick sample makes line_idle 0.
- R10: rx_active stays 1 after a frame's stop bit until the idle time of R9 has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| data_rd | input | 1 | Read strobe for the data register |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Ninth received bit |
| data_full | output | 1 | Unread data present |
| frame_err | output | 1 | Stop bit of the held frame was 0 |
| overrun | output | 1 | A frame was dropped because data was unread |
| line_idle | output | 1 | Line high for a full character time |
| rx_active | output | 1 | Reception in progress |

## Verification
The read strobe and the completion of a frame can land on the same clock edge, and the design must then accept the new frame rather than flag an overrun. The bench provokes this in two steps. It first measures, on a clean frame, how many cycles pass from the start bit to data_full rising. It then leaves one frame unread and replays an identical timing with data_rd pulsed exactly on the loading edge. It judges the result by data_full staying 1, overrun staying 0 and rx_data showing the second byte. A companion case without the pulse must instead keep the first byte and set overrun.

// File: rtl/uart_rx_active.sv
module uart_rx_active #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rxd,
  input  logic          nine_bit,
  input  logic          data_rd,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          data_full,
  output logic          frame_err,
  output logic          overrun,
  output logic          line_idle,
  output logic          rx_active
);
  localparam int CW    = $clog2(OSR);
  localparam int HALF  = OSR / 2 - 1;
  localparam int IDL8  = OSR * (DW + 2);
  localparam int IDL9  = OSR * (DW + 3);
  localparam int IW    = $clog2(IDL9 + 1);
  localparam int BW    = $clog2(DW + 2);

  typedef enum logic [1:0] {S_WAIT, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bcnt;
  logic [DW:0]   sh;
  logic [IW-1:0] icnt;

  wire [BW-1:0] last_bit   = nine_bit ? BW'(DW) : BW'(DW - 1);
  wire [IW-1:0] idle_lim   = nine_bit ? IW'(IDL9) : IW'(IDL8);
  wire          mid_start  = os_tick && st == S_START && tcnt == CW'(HALF);
  wire          frame_done = os_tick && st == S_STOP && tcnt == CW'(OSR - 1);
  wire          accept     = frame_done && (!data_full || data_rd);
  wire          start_seen = os_tick && st == S_WAIT && !rxd;
  wire          idle_hit   = os_tick && rxd && icnt == idle_lim - IW'(1);

  assign line_idle = icnt >= idle_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_WAIT;
      tcnt <= '0;
      bcnt <= '0;
      sh   <= '0;
    end else if (os_tick) begin
      case (st)
        S_WAIT: if (!rxd) begin
          st   <= S_START;
          tcnt <= '0;
        end
        S_START: if (tcnt == CW'(HALF)) begin
          tcnt <= '0;
          bcnt <= '0;
          st   <= rxd ? S_WAIT : S_DATA;
        end else tcnt <= tcnt + 1'b1;
        S_DATA: if (tcnt == CW'(OSR - 1)) begin
          tcnt <= '0;
          sh   <= {rxd, sh[DW:1]};
          if (bcnt == last_bit) st <= S_STOP;
          else bcnt <= bcnt + 1'b1;
        end else tcnt <= tcnt + 1'b1;
        S_STOP: if (tcnt == CW'(OSR - 1)) st <= S_WAIT;
                else tcnt <= tcnt + 1'b1;
        default: st <= S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_bit9   <= 1'b0;
      data_full <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (accept) begin
        rx_data   <= nine_bit ? sh[DW-1:0] : sh[DW:1];
        rx_bit9   <= nine_bit & sh[DW];
        frame_err <= !rxd;
        data_full <= 1'b1;
      end else if (data_rd) data_full <= 1'b0;
      if (frame_done && data_full && !data_rd) overrun <= 1'b1;
      else if (data_rd) overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt      <= '0;
      rx_active <= 1'b0;
    end else begin
      if (os_tick) begin
        if (!rxd) icnt <= '0;
        else if (icnt < idle_lim) icnt <= icnt + 1'b1;
      end
      if (start_seen) rx_active <= 1'b1;
      else if ((mid_start && rxd) || idle_hit) rx_active <= 1'b0;
    end
  end

  a_r2_active_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(os_tick && !rxd));
  a_r4_no_bit9_in_8bit: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !nine_bit) |=> !rx_bit9);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !frame_done) |=> !data_full && !overrun);
  a_r7_overrun_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && data_full && !data_rd) |=> overrun && data_full && $stable(rx_data));
  a_r8_read_and_load: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && data_rd) |=> data_full && !overrun);
  a_r9_idle_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    line_idle |-> !rx_active);
endmodule

// File: tb/test_uart_rx_active.sv
module test_uart_rx_active;
  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
  logic nine_bit = 1'b0, data_rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit9, data_full, frame_err, overrun, line_idle, rx_active;
  int total = 0, bad = 0, cal_l = -1;

  always #2.5 clk = ~clk;

  uart_rx_active i_uart_rx_active (.*);

  // {nine_bit, stop, data[8:0]}
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 1'b1, 9'h0A5}, {1'b0, 1'b1, 9'h100}, {1'b0, 1'b0, 9'h0FF},
    {1'b1, 1'b1, 9'h13C}, {1'b1, 1'b1, 9'h0C3}, {1'b1, 1'b0, 9'h1FF}};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    os_tick = ~os_tick;
  endtask

  task automatic wait_bits(input int n);
    repeat (n * 32) step();
  endtask

  task automatic pulse_rd();
    step(); data_rd = 1'b1;
    step(); data_rd = 1'b0;
  endtask

  task automatic send(input logic m9, input logic [8:0] d, input logic stp, input int rd_at);
    int nb = m9 ? 9 : 8;
    logic was_full = data_full;
    nine_bit = m9;
    if (os_tick) step();
    for (int k = 0; k < (nb + 2) * 32; k++) begin
      int bi = k / 32;
      step();
      rxd = (bi == 0) ? 1'b0 : (bi <= nb) ? d[bi-1] : stp;
      data_rd = (rd_at > 0 && k == rd_at - 1);
      if (cal_l < 0 && rd_at == 0 && !was_full && data_full) cal_l = k;
    end
    step(); rxd = 1'b1; data_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 data_full", data_full, 0); chk("R1 frame_err", frame_err, 0);
    chk("R1 overrun", overrun, 0);     chk("R1 rx_active", rx_active, 0);
    chk("R1 rx_data", rx_data, 0);     chk("R1 rx_bit9", rx_bit9, 0);
    wait_bits(12);
    chk("R9 idle after reset", line_idle, 1);

    for (int i = 0; i < 6; i++) begin
      logic [10:0] v = VEC[i];
      send(v[10], v[8:0], v[9], 0);
      chk("R3 rx_data", rx_data, v[7:0]);
      chk("R4 rx_bit9", rx_bit9, v[10] & v[8]);
      chk("R3 data_full", data_full, 1);
      chk("R5 frame_err", frame_err, !v[9]);
      chk("R10 active after stop", rx_active, 1);
      chk("R9 not idle after frame", line_idle, 0);
      pulse_rd();
      chk("R6 read clears full", data_full, 0);
      chk("R6 data kept", rx_data, v[7:0]);
      chk("R6 frame_err kept", frame_err, !v[9]);
      wait_bits(12);
      chk("R9 line_idle", line_idle, 1);
      chk("R9 active cleared", rx_active, 0);
    end

    // R2 false start: low for 3 ticks only
    nine_bit = 1'b0;
    if (os_tick) step();
    step(); rxd = 1'b0;
    repeat (6) step();
    chk("R2 active on start", rx_active, 1);
    chk("R9 idle drops on low", line_idle, 0);
    rxd = 1'b1;
    repeat (30) step();
    chk("R2 false start abandoned", rx_active, 0);
    chk("R2 no data", data_full, 0);
    wait_bits(12);

    // R7 overrun
    send(1'b0, 9'h011, 1'b1, 0);
    wait_bits(12);
    send(1'b0, 9'h022, 1'b0, 0);
    chk("R7 overrun set", overrun, 1);
    chk("R7 data kept", rx_data, 8'h11);
    chk("R7 frame_err kept", frame_err, 0);
    chk("R7 still full", data_full, 1);
    pulse_rd();
    chk("R6 overrun cleared", overrun, 0);
    chk("R6 full cleared", data_full, 0);
    wait_bits(12);

    // R8 read strobe on the loading edge
    send(1'b0, 9'h033, 1'b1, 0);
    wait_bits(12);
    chk("R8 calibration", (cal_l > 0) ? 1 : 0, 1);
    send(1'b0, 9'h044, 1'b1, cal_l);
    chk("R8 new data", rx_data, 8'h44);
    chk("R8 full kept", data_full, 1);
    chk("R8 no overrun", overrun, 0);
    pulse_rd();
    wait_bits(12);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule